// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from a fast core clock. A programmable divider value is held in an internal register. The total division ratio is that value plus two, so the smallest stored value gives half the core rate. The block has two modes. In identification mode the whole stored value sets the ratio. In data mode only the lowest three bits count. A slow-card input overrides that truncation, so the full value applies in data mode as well.

The block has two outputs. The first is a square-wave card clock. The second is a one-core-cycle strobe that marks each rising edge of the card clock and can serve as a clock enable for logic that runs on the core clock. A new divider value, a mode change or a slow-card change is picked up only when a card clock period ends. A period is therefore never cut short and no runt pulse appears.

Top module: `sdclk_divider`

## Requirements
- R1: In identification mode (`data_mode`=0) the card clock period is the stored 11-bit value plus 2 core cycles, from 2 cycles (value 0) up to 2049 cycles (value 0x7FF).
- R2: The stored value changes only in a cycle where `div_wr` is 1. A change on `div_wdata` while `div_wr` is 0 leaves the period unchanged.
- R3: After reset the stored value is `RST_DIV`, which defaults to 623, giving a period of 625 core cycles.
- R4: In data mode (`data_mode`=1, `slow_card`=0) only bits [2:0] of the stored value count, so the period ranges from 2 to 9 core cycles.
- R5: With `slow_card`=1 the full stored value sets the period in data mode as well.
- R6: Each period starts with a low phase of ceil(N/2) cycles, followed by a high phase of floor(N/2) cycles, where N is the period. For odd N the high phase is one cycle shorter than the low phase.
- R7: `clk_en` is 1 for exactly one core cycle, which is the first cycle in which `card_clk` is high.
- R8: A change of the stored value, the mode or the slow-card input takes effect only at a period boundary. Every period has exactly the phase lengths of either the old setting or the new one.
- R9: While in reset, and in the first cycle after reset, `card_clk` and `clk_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Write strobe for the divider value |
| div_wdata | input | 11 | New divider value (period minus two) |
| data_mode | input | 1 | 0 = identification mode, 1 = data mode |
| slow_card | input | 1 | 1 forces the full divider value in data mode |
| card_clk | output | 1 | Square-wave card clock |
| clk_en | output | 1 | One-cycle strobe at each card clock rising edge |

## Verification
The bench runs the divider at even and odd periods, at the minimum period, at the maximum period and at the reset value. The even and odd cases separate a correct split of the high and low phases from a swapped or rounded one. In data mode the bench uses stored values whose upper bits are set and whose lower bits differ. This shows whether truncation happens, and toggling `slow_card` shows whether the override bypasses it. Every change is made while a period is in progress, and the bench accepts a period only if it matches the old setting or the new one exactly. A write of data without the strobe must leave the period as it was.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    typedef enum logic {
        CLK_MODE_IDENT = 1'b0,
        CLK_MODE_DATA  = 1'b1
    } clk_mode_e;

    // The stored value is the period minus this offset
    localparam int unsigned DIV_OFFSET = 2;

endpackage

// File: rtl/sdclk_div_reg.sv
module sdclk_div_reg #(
    parameter int unsigned DIV_W   = 11,
    parameter int unsigned RST_DIV = 623
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] div_val
);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (wr) begin
            div_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(RST_DIV);
        end else begin
            div_q <= div_d;
        end
    end

    assign div_val = div_q;

endmodule

// File: rtl/sdclk_div_sel.sv
module sdclk_div_sel
    import sdclk_pkg::*;
#(
    parameter int unsigned DIV_W     = 11,
    parameter int unsigned DATA_BITS = 3
) (
    input  logic [DIV_W-1:0] div_val,
    input  clk_mode_e        mode,
    input  logic             slow_card,
    output logic [DIV_W:0]   total
);

    logic [DIV_W-1:0] trunc_val;
    logic [DIV_W-1:0] eff_val;

    // Data-mode view of the divider: only the low bits survive
    generate
        if (DATA_BITS < DIV_W) begin : g_trunc
            assign trunc_val = {{(DIV_W-DATA_BITS){1'b0}}, div_val[DATA_BITS-1:0]};
        end else begin : g_full
            assign trunc_val = div_val;
        end
    endgenerate

    always_comb begin
        if ((mode == CLK_MODE_DATA) && !slow_card) begin
            eff_val = trunc_val;
        end else begin
            eff_val = div_val;
        end
        total = {1'b0, eff_val} + (DIV_W+1)'(DIV_OFFSET);
    end

endmodule

// File: rtl/sdclk_wave_gen.sv
module sdclk_wave_gen #(
    parameter int unsigned CNT_W     = 12,
    parameter int unsigned RESET_TOT = 625
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] next_tot,
    output logic             card_clk,
    output logic             rise_stb
);

    localparam logic [CNT_W-1:0] RST_TOT_V = CNT_W'(RESET_TOT);
    localparam logic [CNT_W-1:0] RST_LOW_V = RST_TOT_V - (RST_TOT_V >> 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] tot;
        logic [CNT_W-1:0] low;
        logic             ck;
        logic             stb;
    } wave_t;

    wave_t s_d, s_q;
    logic  wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == (s_q.tot - CNT_W'(1)));
        if (wrap) begin
            // Period boundary: the only point where a new setting is adopted
            s_d.cnt = '0;
            s_d.tot = next_tot;
            s_d.low = next_tot - (next_tot >> 1);
            s_d.ck  = 1'b0;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
            s_d.ck  = (s_d.cnt >= s_q.low);
        end
        s_d.stb = s_d.ck & ~s_q.ck;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.tot <= RST_TOT_V;
            s_q.low <= RST_LOW_V;
            s_q.ck  <= 1'b0;
            s_q.stb <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign card_clk = s_q.ck;
    assign rise_stb = s_q.stb;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
#(
    parameter int unsigned DIV_W     = 11,
    parameter int unsigned DATA_BITS = 3,
    parameter int unsigned RST_DIV   = 623
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             data_mode,
    input  logic             slow_card,
    output logic             card_clk,
    output logic             clk_en
);

    localparam int unsigned CNT_W     = DIV_W + 1;
    localparam int unsigned RESET_TOT = RST_DIV + DIV_OFFSET;

    logic [DIV_W-1:0] div_val;
    logic [CNT_W-1:0] total;
    clk_mode_e        mode;

    assign mode = clk_mode_e'(data_mode);

    sdclk_div_reg #(
        .DIV_W   (DIV_W),
        .RST_DIV (RST_DIV)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (div_wr),
        .wdata   (div_wdata),
        .div_val (div_val)
    );

    sdclk_div_sel #(
        .DIV_W     (DIV_W),
        .DATA_BITS (DATA_BITS)
    ) u_sel (
        .div_val   (div_val),
        .mode      (mode),
        .slow_card (slow_card),
        .total     (total)
    );

    sdclk_wave_gen #(
        .CNT_W     (CNT_W),
        .RESET_TOT (RESET_TOT)
    ) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .next_tot (total),
        .card_clk (card_clk),
        .rise_stb (clk_en)
    );

endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk #(
    parameter int unsigned DIV_W = 11
) (
    input logic clk,
    input logic rst_n,
    input logic card_clk,
    input logic clk_en
);

    localparam int unsigned CNT_W   = DIV_W + 1;
    localparam int unsigned MAX_TOT = (1 << DIV_W) + 1;
    localparam int unsigned MAX_RUN = MAX_TOT - (MAX_TOT / 2);

    logic             prev_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] lo_len_q;
    logic             have_lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= 1'b0;
            run_q     <= '0;
            lo_len_q  <= '0;
            have_lo_q <= 1'b0;
        end else begin
            prev_q <= card_clk;
            if (card_clk != prev_q) begin
                run_q <= CNT_W'(1);
            end else if (run_q != '1) begin
                run_q <= run_q + CNT_W'(1);
            end
            if (card_clk && !prev_q) begin
                lo_len_q  <= run_q;
                have_lo_q <= 1'b1;
            end
        end
    end

    // R7: every rising card clock edge carries the strobe
    p_rise_has_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> clk_en);

    // R7: the strobe only appears in the first high cycle
    p_stb_at_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (card_clk && !$past(card_clk)));

    // R6: high phase equals the low phase or is one cycle shorter
    p_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_clk && prev_q && have_lo_q) |->
            ((lo_len_q == run_q) || (lo_len_q == run_q + CNT_W'(1))));

    // R1: no phase outlasts the longest legal divisor
    p_run_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CNT_W'(MAX_RUN));

endmodule

bind sdclk_divider sdclk_divider_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .card_clk (card_clk),
    .clk_en   (clk_en)
);

// File: tb/sdclk_divider_bench.sv
module sdclk_divider_bench;

    typedef struct {
        bit    exact;
        int    lo;
        int    hi;
        int    alt_lo;
        int    alt_hi;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_wr = 1'b0;
    logic [10:0] div_wdata = '0;
    logic        data_mode = 1'b0;
    logic        slow_card = 1'b0;
    logic        card_clk;
    logic        clk_en;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t q[$];

    int m_div = 623;
    bit m_mode = 1'b0;
    bit m_slow = 1'b0;

    always #5 clk = ~clk;

    sdclk_divider u_sdclk_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .data_mode (data_mode),
        .slow_card (slow_card),
        .card_clk  (card_clk),
        .clk_en    (clk_en)
    );

    task automatic chk(input bit ok, input string req, input int act_a, input int act_b,
                       input int exp_a, input int exp_b);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=(%0d,%0d) expected=(%0d,%0d)", req, act_a, act_b, exp_a, exp_b);
        end
    endtask

    function automatic int model_tot();
        if (m_mode && !m_slow) return (m_div & 7) + 2;
        return m_div + 2;
    endfunction

    // Monitor: measures each card clock period and compares with the queue
    bit prev_c = 1'b0;
    bit started = 1'b0;
    bit stb_bad = 1'b0;
    int lo_n = 0;
    int hi_n = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_c = 1'b0; started = 1'b0; stb_bad = 1'b0; lo_n = 0; hi_n = 0;
        end else begin
            if (clk_en !== (card_clk && !prev_c)) stb_bad = 1'b1;
            if (!card_clk && prev_c) begin
                if (started && q.size() > 0) begin
                    exp_t it;
                    it = q.pop_front();
                    if (it.exact)
                        chk((lo_n == it.lo) && (hi_n == it.hi), it.tag, lo_n, hi_n, it.lo, it.hi);
                    else
                        chk(((lo_n == it.lo) && (hi_n == it.hi)) ||
                            ((lo_n == it.alt_lo) && (hi_n == it.alt_hi)),
                            it.tag, lo_n, hi_n, it.alt_lo, it.alt_hi);
                    chk(!stb_bad, "R7", int'(stb_bad), 0, 0, 0);
                end
                started = 1'b1; lo_n = 1; hi_n = 0; stb_bad = 1'b0;
            end else if (!card_clk) begin
                lo_n++;
            end else begin
                hi_n++;
            end
            prev_c = card_clk;
        end
    end

    // Driver: applies a setting and pushes the expected periods
    task automatic apply(input int div, input bit wr, input bit mode, input bit slow,
                         input int n, input string tag);
        int old_t, new_t;
        exp_t it;
        old_t = model_tot();
        @(negedge clk);
        if (wr) m_div = div;
        m_mode = mode;
        m_slow = slow;
        new_t = model_tot();
        if (new_t != old_t) begin
            for (int k = 0; k < 2; k++) begin
                it.exact  = 1'b0;
                it.lo     = old_t - old_t / 2;
                it.hi     = old_t / 2;
                it.alt_lo = new_t - new_t / 2;
                it.alt_hi = new_t / 2;
                it.tag    = "R8";
                q.push_back(it);
            end
        end
        for (int k = 0; k < n; k++) begin
            it.exact  = 1'b1;
            it.lo     = new_t - new_t / 2;
            it.hi     = new_t / 2;
            it.alt_lo = it.lo;
            it.alt_hi = it.hi;
            it.tag    = tag;
            q.push_back(it);
        end
        div_wdata = 11'(div);
        div_wr    = wr;
        data_mode = mode;
        slow_card = slow;
        @(negedge clk);
        div_wr = 1'b0;
        wait (q.size() == 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!card_clk && !clk_en, "R9", int'(card_clk), int'(clk_en), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!card_clk && !clk_en, "R9", int'(card_clk), int'(clk_en), 0, 0);

        apply(623, 1'b0, 1'b0, 1'b0, 2, "R3");     // reset value, period 625
        apply(0, 1'b1, 1'b0, 1'b0, 3, "R1");       // fastest, period 2
        apply(1, 1'b1, 1'b0, 1'b0, 3, "R6");       // odd period 3
        apply(4, 1'b1, 1'b0, 1'b0, 3, "R6");       // even period 6
        apply(12'h300, 1'b0, 1'b0, 1'b0, 3, "R2"); // data without strobe ignored
        apply(3, 1'b1, 1'b0, 1'b0, 3, "R1");       // period 5
        apply(12'h7FF, 1'b1, 1'b0, 1'b0, 2, "R1"); // slowest, period 2049
        apply(12'h7FF, 1'b0, 1'b1, 1'b0, 3, "R4"); // data mode: low bits 7 -> 9
        apply(12'h7FD, 1'b1, 1'b1, 1'b0, 3, "R4"); // low bits 5 -> 7
        apply(0, 1'b1, 1'b1, 1'b0, 3, "R4");       // data mode fastest, 2
        apply(13, 1'b1, 1'b1, 1'b0, 3, "R4");      // low bits 5 -> 7
        apply(13, 1'b0, 1'b1, 1'b1, 3, "R5");      // slow card, full 15
        apply(13, 1'b0, 1'b1, 1'b0, 3, "R5");      // override off, back to 7
        apply(13, 1'b0, 1'b0, 1'b0, 3, "R1");      // identification, 15

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=(0,0) expected=(1,1)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule